// File: doc/BRIEF.md
# Split-Group Address Parity Checker

This block guards the request address of a system bus whose address field spans bits 35 down to 3, so 33 lines address a 2^36-byte space. All address, strobe, parity and error lines are active low. Parity is split into two unequal groups. The upper group covers bits 35..24 and has its own parity line. The lower group covers bits 23..3 and has a second parity line.

A check runs only for a cycle in which the address strobe is asserted. In every other cycle the address lines carry other transaction data, and the block ignores them. When either group fails, the block drives its active-low address-error output for one clock. It also sets a sticky status flag for the group that failed.

When reset is released, the block captures one address line as a configuration bit. That bit decides whether an address error seen on the bus produces an abort pulse for the current transaction. The bus error can come from another agent or from this block's own drive.

Top module: `split_parity_guard`

## Requirements
- R1: While `rst_n` is low, the outputs read `err_drv_n`=1, `abort`=0, `hi_fail`=0, `lo_fail`=0 and `obs_en`=0.
- R2: The upper group is bits 35..24 of `addr_n` together with `par_hi_n`, all taken as electrical values. It passes when the XOR of these 13 bits is 0 (even parity). If a strobe cycle (`strobe_n`=0) fails this test, `err_drv_n` is 0 for exactly the one cycle that lies two clocks after the strobe cycle.
- R3: The lower group is bits 23..3 of `addr_n` together with `par_lo_n`. It uses the same even-parity rule and the same two-cycle timing as R2.
- R4: In a cycle where `strobe_n`=1, the values on `addr_n`, `par_hi_n` and `par_lo_n` have no effect. `err_drv_n` stays 1 two cycles later.
- R5: Strobes on consecutive cycles are each checked on their own. The `err_drv_n` pattern matches the strobe pattern, delayed by two cycles, with no error dropped or merged.
- R6: `hi_fail` and `lo_fail` go to 1 at the clock edge that ends the cycle in which `err_drv_n` is low for their group. They stay set until `clr_sticky` is 1 at a clock edge. If a clear and a new failure meet at the same edge, the flag stays set.
- R7: At the first clock edge after `rst_n` rises, `obs_en` takes the inverse of `addr_n[7]`, so a low line enables observation. `obs_en` then holds that value until the next reset.
- R8: When `obs_en`=1, `abort` is 1 for one cycle after each cycle in which the bus error is active. The bus error is active when `err_in_n`=0 or `err_drv_n`=0. When `obs_en`=0, `abort` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_n | input | 33 | Address lines, bits 35..3, active low |
| strobe_n | input | 1 | Address strobe, active low |
| par_hi_n | input | 1 | Parity for bits 35..24 |
| par_lo_n | input | 1 | Parity for bits 23..3 |
| err_in_n | input | 1 | Address error observed from the bus, active low |
| clr_sticky | input | 1 | Clears the sticky group flags |
| err_drv_n | output | 1 | Address error driven by this agent, active low |
| abort | output | 1 | Transaction abort pulse |
| hi_fail | output | 1 | Sticky flag: upper group failed |
| lo_fail | output | 1 | Sticky flag: lower group failed |
| obs_en | output | 1 | Captured error-observation enable |

## Verification
Two collisions can land on one clock edge. A clear pulse can meet a new group failure that is setting the same sticky flag. An external error can arrive in the same cycle as this block's own error drive. The bench steers `clr_sticky` onto the exact edge where a delayed failure lands. It also asserts `err_in_n` in the same cycle as, and in the cycles next to, the block's own error. A behavioural model then judges each result: the flag must survive the clear, and there must be one abort pulse per active error cycle. Random traffic then repeats these overlaps with observation both enabled and disabled.

// File: rtl/split_parity_guard.sv
module split_parity_guard #(
  parameter int ADDR_HI    = 35,
  parameter int ADDR_LO    = 3,
  parameter int SPLIT_LO   = 24,
  parameter int CFG_LINE   = 7,
  parameter int ODD_PARITY = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_HI:ADDR_LO] addr_n,
  input  logic                   strobe_n,
  input  logic                   par_hi_n,
  input  logic                   par_lo_n,
  input  logic                   err_in_n,
  input  logic                   clr_sticky,
  output logic                   err_drv_n,
  output logic                   abort,
  output logic                   hi_fail,
  output logic                   lo_fail,
  output logic                   obs_en
);
  localparam int   HI_W = ADDR_HI - SPLIT_LO + 1;
  localparam int   LO_W = SPLIT_LO - ADDR_LO;
  localparam logic POL  = (ODD_PARITY != 0);

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            ph_q, pl_q, v1_q;
  logic            hi_bad_q, lo_bad_q;
  logic            released_q;
  logic            bus_err;

  assign err_drv_n = !(hi_bad_q || lo_bad_q);
  assign bus_err   = !err_in_n || !err_drv_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      ph_q <= 1'b0;
      pl_q <= 1'b0;
      v1_q <= 1'b0;
    end else begin
      v1_q <= !strobe_n;
      if (!strobe_n) begin
        hi_q <= addr_n[ADDR_HI:SPLIT_LO];
        lo_q <= addr_n[SPLIT_LO-1:ADDR_LO];
        ph_q <= par_hi_n;
        pl_q <= par_lo_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_bad_q <= 1'b0;
      lo_bad_q <= 1'b0;
    end else begin
      hi_bad_q <= v1_q && ((^{hi_q, ph_q}) ^ POL);
      lo_bad_q <= v1_q && ((^{lo_q, pl_q}) ^ POL);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_fail <= 1'b0;
      lo_fail <= 1'b0;
      abort   <= 1'b0;
    end else begin
      hi_fail <= (hi_fail && !clr_sticky) || hi_bad_q;
      lo_fail <= (lo_fail && !clr_sticky) || lo_bad_q;
      abort   <= obs_en && bus_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      released_q <= 1'b0;
      obs_en     <= 1'b0;
    end else begin
      released_q <= 1'b1;
      if (!released_q) obs_en <= !addr_n[CFG_LINE];
    end
  end
endmodule

// File: rtl/split_parity_guard_chk.sv
module split_parity_guard_chk #(
  parameter int ADDR_HI    = 35,
  parameter int ADDR_LO    = 3,
  parameter int SPLIT_LO   = 24,
  parameter int ODD_PARITY = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_HI:ADDR_LO] addr_n,
  input logic                   strobe_n,
  input logic                   par_hi_n,
  input logic                   par_lo_n,
  input logic                   err_in_n,
  input logic                   clr_sticky,
  input logic                   err_drv_n,
  input logic                   abort,
  input logic                   hi_fail,
  input logic                   lo_fail,
  input logic                   obs_en
);
  localparam logic POL = (ODD_PARITY != 0);
  logic hi_mis, lo_mis;
  assign hi_mis = (^{addr_n[ADDR_HI:SPLIT_LO], par_hi_n}) ^ POL;
  assign lo_mis = (^{addr_n[SPLIT_LO-1:ADDR_LO], par_lo_n}) ^ POL;

  // R1
  always @(posedge clk)
    if (!rst_n)
      reset_state_chk: assert (err_drv_n && !abort && !hi_fail && !lo_fail && !obs_en);

  // R2
  hi_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && hi_mis) |-> ##2 !err_drv_n);

  // R3
  lo_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && lo_mis) |-> ##2 !err_drv_n);

  // R4
  err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_drv_n |-> $past(!strobe_n, 2));

  // R6
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_fail) || $rose(lo_fail)) |-> $past(!err_drv_n));

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_fail && !clr_sticky) |=> hi_fail);

  // R8
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(obs_en && (!err_in_n || !err_drv_n)));

  // R8
  abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_en && !err_in_n) |=> abort);
endmodule

bind split_parity_guard split_parity_guard_chk #(
  .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT_LO(SPLIT_LO), .ODD_PARITY(ODD_PARITY)
) u_chk (.*);

// File: tb/split_parity_guard_test.sv
module split_parity_guard_test;
  localparam int PERIOD = 10;
  localparam int CFG = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:3] addr_n = '1;
  logic        strobe_n = 1'b1, par_hi_n = 1'b1, par_lo_n = 1'b1;
  logic        err_in_n = 1'b1, clr_sticky = 1'b0;
  logic        err_drv_n, abort, hi_fail, lo_fail, obs_en;

  split_parity_guard uut (
    .clk(clk), .rst_n(rst_n), .addr_n(addr_n), .strobe_n(strobe_n),
    .par_hi_n(par_hi_n), .par_lo_n(par_lo_n), .err_in_n(err_in_n),
    .clr_sticky(clr_sticky), .err_drv_n(err_drv_n), .abort(abort),
    .hi_fail(hi_fail), .lo_fail(lo_fail), .obs_en(obs_en)
  );

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0;
  string phase = "R1";

  logic [1:0] pipe[$];
  logic [1:0] m_out;
  logic m_abort, m_hi, m_lo, m_en, m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = {2'b00};
      m_out = 2'b00; m_abort = 0; m_hi = 0; m_lo = 0; m_en = 0; m_rel = 0;
    end else begin
      logic [1:0] fresh;
      m_abort = m_en && (!err_in_n || (m_out != 2'b00));
      m_hi = (m_hi && !clr_sticky) || m_out[1];
      m_lo = (m_lo && !clr_sticky) || m_out[0];
      fresh = 2'b00;
      if (!strobe_n) fresh = {^{addr_n[35:24], par_hi_n}, ^{addr_n[23:3], par_lo_n}};
      pipe.push_back(fresh);
      m_out = pipe.pop_front();
      if (!m_rel) begin m_en = !addr_n[CFG]; m_rel = 1; end
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%b expected=%b", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    cmp("R2/R3 err_drv_n", err_drv_n, !(m_out != 2'b00));
    cmp("R8 abort", abort, m_abort);
    cmp("R6 hi_fail", hi_fail, m_hi);
    cmp("R6 lo_fail", lo_fail, m_lo);
    cmp("R7 obs_en", obs_en, m_en);
  end

  task automatic step(input logic s, input logic [35:3] a, input logic hb, input logic lb,
                      input logic ei, input logic clr);
    @(posedge clk); #1;
    strobe_n = s; addr_n = a;
    par_hi_n = (^a[35:24]) ^ hb;
    par_lo_n = (^a[23:3]) ^ lb;
    err_in_n = ei; clr_sticky = clr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, '1, 0, 0, 1, 0);
  endtask

  task automatic do_reset(input logic cfg_line);
    @(posedge clk); #1;
    phase = "R1"; rst_n = 0; strobe_n = 1; err_in_n = 1; clr_sticky = 0;
    addr_n = '1; addr_n[CFG] = cfg_line;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    phase = "R7";
    @(posedge clk); #1;
  endtask

  task automatic scenario(input logic en_line);
    do_reset(en_line);
    idle(2);
    phase = "R2";
    step(0, 33'h0_1234_5678, 1, 0, 1, 0); idle(4);
    phase = "R3";
    step(0, 33'h1_0F0F_0F0F, 0, 1, 1, 0); idle(2);
    step(0, 33'h0_AAAA_5555, 0, 0, 1, 0); idle(2);
    step(0, 33'h1_FFFF_FFFF, 1, 1, 1, 0); idle(4);
    phase = "R4";
    for (int i = 0; i < 6; i++) step(1, 33'h0_DEAD_BEEF + 33'(i), 1, 1, 1, 0);
    idle(3);
    phase = "R5";
    step(0, 33'h0_1111_1111, 1, 0, 1, 0);
    step(0, 33'h0_2222_2222, 0, 0, 1, 0);
    step(0, 33'h0_3333_3333, 0, 1, 1, 0);
    step(0, 33'h0_4444_4444, 1, 1, 1, 0);
    step(0, 33'h0_5555_5555, 1, 0, 1, 0);
    idle(4);
    phase = "R6";
    step(1, '1, 0, 0, 1, 1); idle(2);
    step(0, 33'h0_0000_0001, 1, 1, 1, 0);
    idle(1);
    step(1, '1, 0, 0, 1, 1);
    step(1, '1, 0, 0, 1, 0);
    step(1, '1, 0, 0, 1, 1);
    idle(3);
    phase = "R8";
    step(1, '1, 0, 0, 0, 0); idle(2);
    step(0, 33'h0_0000_0010, 1, 0, 1, 0);
    step(1, '1, 0, 0, 1, 0);
    step(1, '1, 0, 0, 0, 0);
    step(1, '1, 0, 0, 0, 0);
    idle(3);
    phase = "R5";
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) == 0, {$urandom, 1'b0}, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 9) != 0, ($urandom % 11) == 0);
    idle(4);
  endtask

  initial begin
    fork
      begin
        scenario(1'b0);
        scenario(1'b1);
      end
      begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule